// File: doc/BRIEF.md
# Merged-State Path-Vector Matcher

This block scans a byte stream for a set of fixed strings, using a state machine held in loadable tables. To save table space, states that several strings pass through in the same way share one entry. Each state entry carries a pattern mask, with one bit per string whose path runs through that state, and a flag that marks the state as the end of a string. While the machine walks the stream, a running mask is ANDed with the mask of every state it enters. Strings that share a state therefore stay apart, because only the bits of strings consistent with the path actually taken survive.

Software or a loader fills two tables through write ports. The transition table gives the next state for each (state, byte) pair, where next state 0 means there is no forward edge. The attribute table gives the pattern mask and the end flag of each state. The stream is then presented one byte per cycle. One cycle after each valid byte, the block reports a vector that names every string ending on that byte.

Top module: `pvm_matcher`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `match_valid` and `match_o` are 0. After reset the machine sits at the root (state 0) with a running mask of all ones, so a stream with only the tail of a string produces no match.
- R2: For each valid byte the next state is read from the transition table at (current state, byte). A stored value of 0 means that no forward edge exists.
- R3: On entering a state, the running mask becomes the old mask ANDed with that state's pattern mask. A reported match vector equals the running mask held after the byte.
- R4: A match is reported only when the entered state has its end flag set and the new running mask is nonzero. Bit i of `match_o` is 1 exactly when string i ends on that byte.
- R5: A shared state tells its strings apart. A path that entered it through string A's prefix never reports string B, even when B's final state is reached.
- R6: A byte with no forward edge, or whose edge would leave the running mask at zero, restarts the machine at the root in the same cycle. The same byte is then looked up from state 0 with a mask of all ones. If that lookup also fails, the machine goes to state 0 with a mask of all ones.
- R7: When `in_valid` is low, the state and mask are unchanged, and in the next cycle `match_valid` is 0 and `match_o` is 0.
- R8: The outputs are registered. `match_valid` equals the `in_valid` of the previous cycle, and the result for a byte appears in the cycle after the byte is presented.
- R9: A write through either table port takes effect for lookups in the following cycles. Clearing a state's end flag stops its string from being reported, and setting the flag again brings the reports back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream byte is present |
| in_byte | input | SYM_W | Stream byte |
| tr_we | input | 1 | Write enable, transition table |
| tr_state | input | STATE_W | Source state of the transition written |
| tr_sym | input | SYM_W | Byte of the transition written |
| tr_next | input | STATE_W | Next state written (0 = no forward edge) |
| at_we | input | 1 | Write enable, attribute table |
| at_state | input | STATE_W | State whose attributes are written |
| at_pvec | input | NPAT | Pattern mask written |
| at_final | input | 1 | End flag written |
| match_valid | output | 1 | Result for the previous cycle's byte |
| match_o | output | NPAT | Strings that end on that byte |

## Verification
The hardest case to reach from the ports is a shared state entered through one string's prefix and then left toward another string's final state. In that case the table would produce a match if the running mask did not clear it. The bench loads three strings, "abc", "xbd" and "kbd". All three share the 'b' state, and the last two also share their final 'd' state. The bench then sends directed sequences such as "abd" and "kbc", followed by a long random stream over the same six letters with idle gaps. An independent suffix-comparison model predicts every cycle's output, and a mid-stream change to an end flag exercises table updates.

// File: rtl/pvm_pkg.sv
package pvm_pkg;
  localparam int unsigned DEF_STATE_W = 3;
  localparam int unsigned DEF_SYM_W   = 8;
  localparam int unsigned DEF_NPAT    = 4;
endpackage

// File: rtl/pvm_trans_ram.sv
module pvm_trans_ram #(
  parameter int unsigned STATE_W = pvm_pkg::DEF_STATE_W,
  parameter int unsigned SYM_W   = pvm_pkg::DEF_SYM_W
) (
  input  logic               clk,
  input  logic               we,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [SYM_W-1:0]   wr_sym,
  input  logic [STATE_W-1:0] wr_next,
  input  logic [STATE_W-1:0] rd_state,
  input  logic [SYM_W-1:0]   rd_sym,
  output logic [STATE_W-1:0] rd_next,
  output logic [STATE_W-1:0] root_next
);
  localparam int unsigned ADDR_W = STATE_W + SYM_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [STATE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wr_state, wr_sym}] <= wr_next;
  end

  assign rd_next   = mem[{rd_state, rd_sym}];
  assign root_next = mem[{{STATE_W{1'b0}}, rd_sym}];
endmodule

// File: rtl/pvm_attr_ram.sv
module pvm_attr_ram #(
  parameter int unsigned STATE_W = pvm_pkg::DEF_STATE_W,
  parameter int unsigned NPAT    = pvm_pkg::DEF_NPAT
) (
  input  logic               clk,
  input  logic               we,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [NPAT-1:0]    wr_pvec,
  input  logic               wr_final,
  input  logic [STATE_W-1:0] rd_a,
  output logic [NPAT-1:0]    pvec_a,
  output logic               final_a,
  input  logic [STATE_W-1:0] rd_b,
  output logic [NPAT-1:0]    pvec_b,
  output logic               final_b
);
  localparam int unsigned DEPTH = 1 << STATE_W;
  localparam int unsigned WORD  = NPAT + 1;

  logic [WORD-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_state] <= {wr_final, wr_pvec};
  end

  assign {final_a, pvec_a} = mem[rd_a];
  assign {final_b, pvec_b} = mem[rd_b];
endmodule

// File: rtl/pvm_step.sv
module pvm_step #(
  parameter int unsigned STATE_W = pvm_pkg::DEF_STATE_W,
  parameter int unsigned NPAT    = pvm_pkg::DEF_NPAT
) (
  input  logic [NPAT-1:0]    path_cur,
  input  logic [STATE_W-1:0] fwd_state,
  input  logic [NPAT-1:0]    fwd_pvec,
  input  logic               fwd_final,
  input  logic [STATE_W-1:0] root_state,
  input  logic [NPAT-1:0]    root_pvec,
  input  logic               root_final,
  output logic [STATE_W-1:0] state_nx,
  output logic [NPAT-1:0]    path_nx,
  output logic [NPAT-1:0]    hit_vec
);
  localparam logic [NPAT-1:0] ALL_ONES = {NPAT{1'b1}};

  logic [NPAT-1:0] fwd_path;
  logic            fwd_ok;
  logic            root_ok;

  assign fwd_path = path_cur & fwd_pvec;
  assign fwd_ok   = (fwd_state != '0) && (fwd_path != '0);
  assign root_ok  = (root_state != '0) && (root_pvec != '0);

  always_comb begin
    state_nx = '0;
    path_nx  = ALL_ONES;
    hit_vec  = '0;
    if (fwd_ok) begin
      state_nx = fwd_state;
      path_nx  = fwd_path;
      hit_vec  = fwd_final ? fwd_path : '0;
    end else if (root_ok) begin
      state_nx = root_state;
      path_nx  = root_pvec;
      hit_vec  = root_final ? root_pvec : '0;
    end
  end
endmodule

// File: rtl/pvm_matcher.sv
module pvm_matcher #(
  parameter int unsigned STATE_W = pvm_pkg::DEF_STATE_W,
  parameter int unsigned SYM_W   = pvm_pkg::DEF_SYM_W,
  parameter int unsigned NPAT    = pvm_pkg::DEF_NPAT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [SYM_W-1:0]   in_byte,
  input  logic               tr_we,
  input  logic [STATE_W-1:0] tr_state,
  input  logic [SYM_W-1:0]   tr_sym,
  input  logic [STATE_W-1:0] tr_next,
  input  logic               at_we,
  input  logic [STATE_W-1:0] at_state,
  input  logic [NPAT-1:0]    at_pvec,
  input  logic               at_final,
  output logic               match_valid,
  output logic [NPAT-1:0]    match_o
);
  localparam logic [NPAT-1:0] ALL_ONES = {NPAT{1'b1}};

  logic [STATE_W-1:0] state_q;
  logic [NPAT-1:0]    path_q;
  logic [STATE_W-1:0] fwd_state, root_state, state_nx;
  logic [NPAT-1:0]    fwd_pvec, root_pvec, path_nx, hit_vec;
  logic               fwd_final, root_final;

  pvm_trans_ram #(.STATE_W(STATE_W), .SYM_W(SYM_W)) u_trans (
    .clk      (clk),
    .we       (tr_we),
    .wr_state (tr_state),
    .wr_sym   (tr_sym),
    .wr_next  (tr_next),
    .rd_state (state_q),
    .rd_sym   (in_byte),
    .rd_next  (fwd_state),
    .root_next(root_state)
  );

  pvm_attr_ram #(.STATE_W(STATE_W), .NPAT(NPAT)) u_attr (
    .clk      (clk),
    .we       (at_we),
    .wr_state (at_state),
    .wr_pvec  (at_pvec),
    .wr_final (at_final),
    .rd_a     (fwd_state),
    .pvec_a   (fwd_pvec),
    .final_a  (fwd_final),
    .rd_b     (root_state),
    .pvec_b   (root_pvec),
    .final_b  (root_final)
  );

  pvm_step #(.STATE_W(STATE_W), .NPAT(NPAT)) u_step (
    .path_cur  (path_q),
    .fwd_state (fwd_state),
    .fwd_pvec  (fwd_pvec),
    .fwd_final (fwd_final),
    .root_state(root_state),
    .root_pvec (root_pvec),
    .root_final(root_final),
    .state_nx  (state_nx),
    .path_nx   (path_nx),
    .hit_vec   (hit_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= '0;
      path_q      <= ALL_ONES;
      match_valid <= 1'b0;
      match_o     <= '0;
    end else begin
      match_valid <= in_valid;
      match_o     <= in_valid ? hit_vec : '0;
      if (in_valid) begin
        state_q <= state_nx;
        path_q  <= path_nx;
      end
    end
  end
endmodule

// File: rtl/pvm_matcher_chk.sv
module pvm_matcher_chk #(
  parameter int unsigned STATE_W = pvm_pkg::DEF_STATE_W,
  parameter int unsigned NPAT    = pvm_pkg::DEF_NPAT
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               match_valid,
  input logic [NPAT-1:0]    match_o,
  input logic [STATE_W-1:0] state_q,
  input logic [NPAT-1:0]    path_q
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> match_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!match_valid && match_o == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(state_q) && $stable(path_q))); // R7
  AST_NO_STRAY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (match_o != '0) |-> match_valid); // R4
  AST_REPORT_IS_PATH: assert property (@(posedge clk) disable iff (rst)
    (match_o != '0) |-> (match_o == path_q)); // R3
  AST_ROOT_PATH_ONES: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0) |-> (path_q == {NPAT{1'b1}})); // R6
  AST_LIVE_PATH: assert property (@(posedge clk) disable iff (rst)
    (state_q != '0) |-> (path_q != '0)); // R6
endmodule

bind pvm_matcher pvm_matcher_chk #(.STATE_W(STATE_W), .NPAT(NPAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .match_valid(match_valid),
  .match_o    (match_o),
  .state_q    (state_q),
  .path_q     (path_q)
);

// File: tb/pvm_matcher_bench.sv
`timescale 1ns/1ps
module pvm_matcher_bench;
  localparam int STATE_W = 3;
  localparam int SYM_W   = 8;
  localparam int NPAT    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SYM_W-1:0] in_byte = '0;
  logic tr_we = 1'b0;
  logic [STATE_W-1:0] tr_state = '0;
  logic [SYM_W-1:0] tr_sym = '0;
  logic [STATE_W-1:0] tr_next = '0;
  logic at_we = 1'b0;
  logic [STATE_W-1:0] at_state = '0;
  logic [NPAT-1:0] at_pvec = '0;
  logic at_final = 1'b0;
  logic match_valid;
  logic [NPAT-1:0] match_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  string pats [3] = '{"abc", "xbd", "kbd"};
  bit    active [3] = '{1'b1, 1'b1, 1'b1};
  byte   hist [$];

  always #2.5 clk = ~clk;

  pvm_matcher #(.STATE_W(STATE_W), .SYM_W(SYM_W), .NPAT(NPAT)) u_pvm_matcher (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .tr_we(tr_we), .tr_state(tr_state), .tr_sym(tr_sym), .tr_next(tr_next),
    .at_we(at_we), .at_state(at_state), .at_pvec(at_pvec), .at_final(at_final),
    .match_valid(match_valid), .match_o(match_o)
  );

  task automatic check(input string req, input logic [NPAT:0] act, input logic [NPAT:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/match %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NPAT-1:0] model_hits();
    logic [NPAT-1:0] v = '0;
    for (int i = 0; i < 3; i++) begin
      int n = pats[i].len();
      bit ok = active[i] && (hist.size() >= n);
      for (int k = 0; ok && k < n; k++)
        if (hist[hist.size() - n + k] != pats[i][k]) ok = 0;
      v[i] = ok;
    end
    return v;
  endfunction

  task automatic wr_tr(input int s, input byte c, input int nx);
    @(negedge clk);
    tr_we = 1; tr_state = STATE_W'(s); tr_sym = c; tr_next = STATE_W'(nx);
    @(negedge clk);
    tr_we = 0;
  endtask

  task automatic wr_at(input int s, input int pv, input bit fin);
    @(negedge clk);
    at_we = 1; at_state = STATE_W'(s); at_pvec = NPAT'(pv); at_final = fin;
    @(negedge clk);
    at_we = 0;
  endtask

  // One stream cycle; result compared one edge later against the model.
  task automatic step(input bit v, input byte c, input string req);
    logic [NPAT-1:0] exp;
    @(negedge clk);
    in_valid = v; in_byte = c;
    if (v) begin hist.push_back(c); exp = model_hits(); end
    else exp = '0;
    @(posedge clk); #1;
    check(req, {match_valid, match_o}, {v, exp});
  endtask

  task automatic send(input string s, input string req);
    for (int i = 0; i < s.len(); i++) step(1'b1, s[i], req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", {match_valid, match_o}, '0);
    // clear both tables
    for (int a = 0; a < (1 << (STATE_W + SYM_W)); a++)
      wr_tr(a >> SYM_W, byte'(a), 0);
    for (int s = 0; s < (1 << STATE_W); s++) wr_at(s, 0, 0);
    // state 2 ('b') is shared by all strings, state 5 ('d') by xbd and kbd
    wr_tr(0, "a", 1); wr_tr(0, "x", 4); wr_tr(0, "k", 6);
    wr_tr(1, "b", 2); wr_tr(4, "b", 2); wr_tr(6, "b", 2);
    wr_tr(2, "c", 3); wr_tr(2, "d", 5);
    wr_at(1, 4'b0001, 0); wr_at(4, 4'b0010, 0); wr_at(6, 4'b0100, 0);
    wr_at(2, 4'b0111, 0); wr_at(3, 4'b0001, 1); wr_at(5, 4'b0110, 1);
    @(negedge clk); rst = 0;
    @(posedge clk); #1 check("R1", {match_valid, match_o}, '0);
    send("c", "R1");
    send("abc", "R2");
    send("xbd", "R3");
    send("kbd", "R5");
    send("abd", "R5");
    send("kbc", "R5");
    send("aabc", "R6");
    send("abxbd", "R6");
    send("xbdkbd", "R4");
    step(1'b1, "a", "R7"); step(1'b0, "z", "R7"); step(1'b0, "c", "R7");
    step(1'b1, "b", "R7"); step(1'b0, "q", "R7"); step(1'b1, "c", "R8");
    // mid-stream reset returns to the root
    send("ab", "R1");
    @(negedge clk); rst = 1; in_valid = 0;
    @(posedge clk); #1 check("R1", {match_valid, match_o}, '0);
    @(negedge clk); rst = 0; hist.delete();
    send("c", "R1");
    // table update: drop the end flag of "abc", then restore it
    wr_at(3, 4'b0001, 0); active[0] = 0;
    send("abc", "R9"); send("xbd", "R9");
    wr_at(3, 4'b0001, 1); active[0] = 1;
    send("abc", "R9");
    // random stream over the table alphabet with idle gaps
    begin
      string alpha = "abcdxk";
      void'($urandom(32'd7));
      for (int i = 0; i < 3000; i++) begin
        bit v = ($urandom_range(0, 5) != 0);
        step(v, alpha[$urandom_range(0, 5)], "R6");
      end
    end
    finish_run();
  end
endmodule